// File: doc/BRIEF.md
# External Data Access Stretch Controller

This block sequences the data-memory accesses of a small 8-bit core. The core presents a 16-bit address, a write flag, write data and a request. The block decides where the access goes. When the on-chip memory is enabled, the bottom 1 KB of the address space is served by an internal SRAM. Everything else goes to an external bus that has separate read and write strobes. At the end of every access the block raises a one-clock completion pulse. All timing is counted in machine cycles, which are marked by a one-clock `mc_tick` input.

An external access has two parts. The first is one setup machine cycle, in which the address and write data are driven with no strobe. The second is a strobe phase of `1 + stretch` machine cycles, where stretch is a 3-bit configuration value from 0 to 7. The whole external access therefore lasts 2 to 9 machine cycles. An internal access always lasts exactly 2 machine cycles, whatever the stretch value. When waiting is enabled, a slow device can hold the strobe beyond its programmed length by driving `ext_wait` high. The block only reads that pin; it never drives it.

The controller is one state machine with four states:
- `ST_IDLE`: waiting for a request.
- `ST_SETUP`: the first machine cycle of any access.
- `ST_STROBE`: the external strobe phase.
- `ST_INTACC`: the second machine cycle of an internal access.

It has five transitions:
- accept, from `ST_IDLE` to `ST_SETUP`, on a tick with a request present.
- go-external, from `ST_SETUP` to `ST_STROBE`, on a tick.
- go-internal, from `ST_SETUP` to `ST_INTACC`, on a tick.
- strobe-end, from `ST_STROBE` to `ST_IDLE`, on a tick that is not stalled when the stretch count is exhausted.
- internal-end, from `ST_INTACC` to `ST_IDLE`, on a tick.

The stretch, memory-enable and wait-enable settings sit in a configuration register. That register loads from its inputs on a clock where `cfg_load` is high. The stretch value is copied when a request is accepted.

Top module: `xmem_stretch_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `ext_rd` and `ext_wr` are low, `rd_data` is 00h, stretch is 1, the internal SRAM is disabled and waiting is disabled, so a first access with no configuration load lasts 3 machine cycles on the external bus.
- R2: A request is accepted on a clock edge where `mc_tick` is high, the block is idle and `req` is high. With no wait stall, an external access then stays busy for exactly 2 + stretch ticks, for every stretch value 0 to 7.
- R3: An external access drives no strobe during its first machine cycle. It then asserts `ext_rd` (read, `req_we`=0) or `ext_wr` (write, `req_we`=1) for 1 + stretch machine cycles. The two strobes are never high together. `ext_addr` and, for writes, `ext_wdata` hold the accepted values while a strobe is high.
- R4: With the internal SRAM enabled, addresses 0000h to 03FFh are served internally with no strobe, and addresses from 0400h upward go to the external bus.
- R5: With the internal SRAM disabled, every address, including 0000h, goes to the external bus.
- R6: An internal access lasts exactly 2 ticks regardless of stretch. An internal read returns the byte most recently written to that address.
- R7: With waiting enabled, each tick during the strobe phase at which `ext_wait` is high keeps the strobe asserted and adds one machine cycle to the access.
- R8: `ext_wait` has no effect when waiting is disabled. It also has no effect during the setup cycle or during internal accesses.
- R9: A request presented while an access is in progress is ignored: neither the address nor the length of the current access changes.
- R10: `done` is high for exactly one clock, in the clock that follows the tick ending the last machine cycle, and `busy` is low while `done` is high.
- R11: External read data is taken from `ext_rdata` on the clock edge where `ext_rd` falls. It is held on `rd_data` until the next read completes; writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_tick | input | 1 | One-clock pulse marking each machine-cycle boundary |
| cfg_load | input | 1 | Loads the three configuration inputs |
| cfg_stretch | input | 3 | Stretch value 0 to 7 |
| cfg_sram_en | input | 1 | Enables the internal 1 KB SRAM window |
| cfg_wait_en | input | 1 | Enables sampling of `ext_wait` |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Last read result |
| ext_addr | output | 16 | External bus address |
| ext_wdata | output | 8 | External bus write data |
| ext_rd | output | 1 | External read strobe, active high |
| ext_wr | output | 1 | External write strobe, active high |
| ext_rdata | input | 8 | External bus read data |
| ext_wait | input | 1 | Wait request from the external device, active high |

## Verification
External reads are swept across all eight stretch values. Comparing the tick count against each value separates a correct length from an off-by-one in the strobe count. The same address offsets are tried with the SRAM window disabled and enabled, and on both sides of the 03FFh/0400h boundary; this shows whether routing follows the enable and the window limit. `ext_wait` is raised in the strobe phase with waiting enabled, then with waiting disabled, and finally only in the setup cycle. Together these separate a correct stall from one that ignores the enable or fires outside the strobe. A second request held high through a whole access exposes any controller that re-accepts while busy. Internal write/read-back pairs and external reads with known bus data confirm where read data is captured and how long it is held.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_INTACC = 2'd3
    } xs_state_t;
endpackage

// File: rtl/xmem_route_dec.sv
module xmem_route_dec #(
    parameter int AW      = 16,
    parameter int SRAM_AW = 10
) (
    input  logic [AW-1:0] addr,
    input  logic          win_en,
    output logic          hit_int
);
    localparam int HI_W = AW - SRAM_AW;

    logic [HI_W-1:0] upper;
    assign upper   = addr[AW-1:SRAM_AW];
    assign hit_int = win_en && (upper == '0);
endmodule

// File: rtl/xmem_stretch_cnt.sv
module xmem_stretch_cnt #(
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [SW-1:0] load_val,
    input  logic          step,
    output logic          at_zero
);
    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/xmem_sram.sv
module xmem_sram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/xmem_stretch_ctrl.sv
module xmem_stretch_ctrl
    import xmem_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int SW          = 3,
    parameter int SRAM_AW     = 10,
    parameter int RST_STRETCH = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mc_tick,
    input  logic          cfg_load,
    input  logic [SW-1:0] cfg_stretch,
    input  logic          cfg_sram_en,
    input  logic          cfg_wait_en,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] ext_addr,
    output logic [DW-1:0] ext_wdata,
    output logic          ext_rd,
    output logic          ext_wr,
    input  logic [DW-1:0] ext_rdata,
    input  logic          ext_wait
);
    localparam logic [SW-1:0] STR_RESET = SW'(RST_STRETCH);

    xs_state_t state_q, state_d;

    logic [SW-1:0] cfg_str_q;
    logic          cfg_sram_q;
    logic          cfg_wait_q;

    logic          lat_int, lat_we;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;
    logic [SW-1:0] lat_str;
    logic [DW-1:0] rd_q;
    logic          done_q;

    logic          hit_int;
    logic          accept;
    logic          stall;
    logic          cnt_zero;
    logic          cnt_load;
    logic          cnt_step;
    logic          finish;
    logic          sram_wr;
    logic [DW-1:0] sram_rdata;

    xmem_route_dec #(.AW(AW), .SRAM_AW(SRAM_AW)) u_route (
        .addr    (req_addr),
        .win_en  (cfg_sram_q),
        .hit_int (hit_int)
    );

    assign accept   = (state_q == ST_IDLE) && mc_tick && req;
    assign stall    = cfg_wait_q && ext_wait;
    assign cnt_load = (state_q == ST_SETUP) && mc_tick;
    assign cnt_step = (state_q == ST_STROBE) && mc_tick && !stall;
    assign finish   = ((state_q == ST_STROBE) && mc_tick && !stall && cnt_zero)
                   || ((state_q == ST_INTACC) && mc_tick);
    assign sram_wr  = (state_q == ST_INTACC) && mc_tick && lat_we;

    xmem_stretch_cnt #(.SW(SW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (lat_str),
        .step     (cnt_step),
        .at_zero  (cnt_zero)
    );

    xmem_sram #(.AW(SRAM_AW), .DW(DW)) u_sram (
        .clk   (clk),
        .wr_en (sram_wr),
        .addr  (lat_addr[SRAM_AW-1:0]),
        .wdata (lat_wdata),
        .rdata (sram_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SETUP;
            ST_SETUP:  if (mc_tick) state_d = lat_int ? ST_INTACC : ST_STROBE;
            ST_STROBE: if (mc_tick && !stall && cnt_zero) state_d = ST_IDLE;
            ST_INTACC: if (mc_tick) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy   = 1'b1;
        ext_rd = 1'b0;
        ext_wr = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_SETUP:  busy = 1'b1;
            ST_STROBE: begin
                ext_rd = !lat_we;
                ext_wr = lat_we;
            end
            ST_INTACC: busy = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign done      = done_q;
    assign rd_data   = rd_q;
    assign ext_addr  = lat_addr;
    assign ext_wdata = lat_wdata;

    // Configuration and access datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_str_q  <= STR_RESET;
            cfg_sram_q <= 1'b0;
            cfg_wait_q <= 1'b0;
            lat_int    <= 1'b0;
            lat_we     <= 1'b0;
            lat_addr   <= '0;
            lat_wdata  <= '0;
            lat_str    <= '0;
            rd_q       <= '0;
            done_q     <= 1'b0;
        end else begin
            if (cfg_load) begin
                cfg_str_q  <= cfg_stretch;
                cfg_sram_q <= cfg_sram_en;
                cfg_wait_q <= cfg_wait_en;
            end
            if (accept) begin
                lat_int   <= hit_int;
                lat_we    <= req_we;
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
                lat_str   <= cfg_str_q;
            end
            done_q <= finish;
            if (finish && !lat_we) begin
                rd_q <= lat_int ? sram_rdata : ext_rdata;
            end
        end
    end
endmodule

// File: rtl/xmem_stretch_ctrl_chk.sv
module xmem_stretch_ctrl_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mc_tick,
    input logic          busy,
    input logic          done,
    input logic          ext_rd,
    input logic          ext_wr,
    input logic [AW-1:0] ext_addr,
    input logic          ext_wait,
    input logic          wait_en
);
    logic strobe;
    assign strobe = ext_rd || ext_wr;

    // R3: only one strobe at a time
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_rd && ext_wr));

    // R3: a strobe only begins on a machine-cycle boundary
    a_r3_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(mc_tick));

    // R3: address held while strobing
    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (!strobe || $stable(ext_addr)));

    // R7: wait at a boundary keeps the strobe
    a_r7_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && mc_tick && wait_en && ext_wait) |=> strobe);

    // R10: done is a single clock
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done only while idle
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind xmem_stretch_ctrl xmem_stretch_ctrl_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mc_tick  (mc_tick),
    .busy     (busy),
    .done     (done),
    .ext_rd   (ext_rd),
    .ext_wr   (ext_wr),
    .ext_addr (ext_addr),
    .ext_wait (ext_wait),
    .wait_en  (cfg_wait_q)
);

// File: tb/xmem_stretch_ctrl_test.sv
`timescale 1ns/1ps
module xmem_stretch_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_tick = 1'b0;
    logic        cfg_load = 1'b0;
    logic [2:0]  cfg_stretch = 3'd0;
    logic        cfg_sram_en = 1'b0;
    logic        cfg_wait_en = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        busy, done, ext_rd, ext_wr;
    logic [7:0]  rd_data, ext_wdata, ext_rdata;
    logic [15:0] ext_addr;
    logic        ext_wait = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    xmem_stretch_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick),
        .cfg_load(cfg_load), .cfg_stretch(cfg_stretch),
        .cfg_sram_en(cfg_sram_en), .cfg_wait_en(cfg_wait_en),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_rd(ext_rd), .ext_wr(ext_wr),
        .ext_rdata(ext_rdata), .ext_wait(ext_wait)
    );

    function automatic logic [7:0] xfun(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign ext_rdata = xfun(ext_addr);

    // machine-cycle tick every 4 clocks
    logic [1:0] tcnt = 2'd0;
    always @(negedge clk) begin
        tcnt    <= tcnt + 2'd1;
        mc_tick <= (tcnt == 2'd3);
    end

    // behavioural reference model
    bit          m_busy, m_done, m_int, m_we;
    int          m_el, m_total;
    logic [15:0] m_addr;
    logic [7:0]  m_wd, m_rd;
    int          m_str;
    bit          m_sram, m_wen;
    logic [7:0]  mmem [int];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_rd = 8'h00;
            m_str = 1; m_sram = 0; m_wen = 0;
        end else begin
            m_done = 0;
            if (m_busy && mc_tick) begin
                if (!(!m_int && m_el >= 1 && m_wen && ext_wait)) begin
                    m_el = m_el + 1;
                    if (m_el == m_total) begin
                        m_busy = 0;
                        m_done = 1;
                        if (!m_we) m_rd = m_int ? mmem[int'(m_addr)] : xfun(m_addr);
                        else if (m_int) mmem[int'(m_addr)] = m_wd;
                    end
                end
            end else if (!m_busy && mc_tick && req) begin
                m_busy  = 1;
                m_int   = m_sram && (req_addr < 16'h0400);
                m_total = m_int ? 2 : 2 + m_str;
                m_el    = 0;
                m_we    = req_we;
                m_addr  = req_addr;
                m_wd    = req_wdata;
            end
            if (cfg_load) begin
                m_str  = int'(cfg_stretch);
                m_sram = cfg_sram_en;
                m_wen  = cfg_wait_en;
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            bit strb;
            strb = m_busy && !m_int && (m_el >= 1);
            chk("R2", "busy", int'(busy), int'(m_busy));
            chk("R10", "done", int'(done), int'(m_done));
            chk("R3", "ext_rd", int'(ext_rd), int'(strb && !m_we));
            chk("R3", "ext_wr", int'(ext_wr), int'(strb && m_we));
            chk("R11", "rd_data", int'(rd_data), int'(m_rd));
            if (strb) begin
                chk("R9", "ext_addr", int'(ext_addr), int'(m_addr));
                if (m_we) chk("R3", "ext_wdata", int'(ext_wdata), int'(m_wd));
            end
        end
    end

    // independent counters for explicit checks
    int tk, sk, dk;
    always @(posedge clk) begin
        if (busy && mc_tick) tk++;
        if ((ext_rd || ext_wr) && mc_tick) sk++;
        if (done) dk++;
    end

    task automatic set_cfg(input int s, input bit sram, input bit wen);
        @(negedge clk);
        cfg_load = 1; cfg_stretch = 3'(s); cfg_sram_en = sram; cfg_wait_en = wen;
        @(negedge clk);
        cfg_load = 0;
    endtask

    // wmode: 0 none, 1 wait in strobe for 2 ticks, 2 wait in setup, 3 hold a second request
    task automatic do_acc(input bit we, input logic [15:0] a, input logic [7:0] d, input int wmode);
        @(negedge clk);
        tk = 0; sk = 0; dk = 0;
        req = 1; req_we = we; req_addr = a; req_wdata = d;
        while (!busy) @(negedge clk);
        if (wmode == 3) begin
            req_we = ~we; req_addr = 16'h1234;
        end else begin
            req = 0;
        end
        if (wmode == 2) begin
            ext_wait = 1;
            repeat (4) @(negedge clk);
            ext_wait = 0;
        end
        if (wmode == 1) begin
            while (!(ext_rd || ext_wr)) @(negedge clk);
            ext_wait = 1;
            repeat (8) @(negedge clk);
            ext_wait = 0;
        end
        while (!done) @(negedge clk);
        req = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy at reset", int'(busy), 0);
        chk("R1", "done at reset", int'(done), 0);
        chk("R1", "strobes at reset", int'(ext_rd | ext_wr), 0);
        chk("R1", "rd_data at reset", int'(rd_data), 0);

        // R1/R5 default: external 3 ticks even at 0000h-window address
        do_acc(0, 16'h0010, 8'h00, 0);
        chk("R1", "default ticks", tk, 3);
        chk("R5", "default strobe ticks", sk, 2);
        chk("R11", "ext read data", int'(rd_data), int'(xfun(16'h0010)));
        chk("R10", "done clocks", dk, 1);

        // R2/R3 stretch sweep
        for (int s = 0; s < 8; s++) begin
            set_cfg(s, 0, 0);
            do_acc(s[0], 16'h8000 + 16'(s * 37), 8'(s + 8'h40), 0);
            chk("R2", "ext ticks", tk, 2 + s);
            chk("R3", "strobe ticks", sk, 1 + s);
            chk("R10", "done clocks", dk, 1);
        end

        // R5 disabled SRAM: 0000h write goes out
        set_cfg(0, 0, 0);
        do_acc(1, 16'h0000, 8'h77, 0);
        chk("R5", "strobe at 0000h", sk, 1);

        // R11 write leaves rd_data unchanged
        do_acc(0, 16'hC3C3, 8'h00, 0);
        do_acc(1, 16'h4000, 8'h11, 0);
        chk("R11", "rd_data after write", int'(rd_data), int'(xfun(16'hC3C3)));

        // R4/R6 internal with stretch 7
        set_cfg(7, 1, 1);
        do_acc(1, 16'h03FF, 8'h3C, 0);
        chk("R6", "int write ticks", tk, 2);
        chk("R4", "no strobe 03FFh", sk, 0);
        do_acc(1, 16'h0000, 8'h81, 0);
        do_acc(0, 16'h03FF, 8'h00, 0);
        chk("R6", "int read 03FFh", int'(rd_data), 8'h3C);
        do_acc(0, 16'h0000, 8'h00, 2);
        chk("R6", "int read 0000h", int'(rd_data), 8'h81);
        chk("R8", "wait ignored internal", tk, 2);
        do_acc(0, 16'h0400, 8'h00, 0);
        chk("R4", "0400h external ticks", tk, 9);
        chk("R4", "0400h strobe ticks", sk, 8);

        // R7 wait enabled stretches strobe
        set_cfg(2, 1, 1);
        do_acc(0, 16'h5555, 8'h00, 1);
        chk("R7", "wait ticks", tk, 6);
        chk("R7", "wait strobe ticks", sk, 5);
        chk("R11", "read after wait", int'(rd_data), int'(xfun(16'h5555)));
        do_acc(1, 16'h6000, 8'h99, 2);
        chk("R8", "wait in setup ticks", tk, 4);

        // R8 wait disabled
        set_cfg(2, 1, 0);
        do_acc(0, 16'h7777, 8'h00, 1);
        chk("R8", "wait disabled ticks", tk, 4);

        // R9 request while busy
        set_cfg(3, 0, 0);
        do_acc(0, 16'hABCD, 8'h00, 3);
        chk("R9", "ticks with held req", tk, 5);
        chk("R9", "read data of first req", int'(rd_data), int'(xfun(16'hABCD)));
        chk("R9", "idle after held req", int'(busy), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule